// File: doc/BRIEF.md
# Multi-port GPIO with write-one set and clear

This block is a memory-mapped general-purpose I/O unit. It serves three plain bidirectional ports of 8, 24 and 13 pins, a mixed port, and two fixed-direction groups. The mixed port has 6 bidirectional pins, 22 input-only pins and 24 output-only pins. Software reaches it over a simple single-cycle register bus. A write takes effect on the rising clock edge when `bus_en` and `bus_wr` are high. Read data is combinational from the address while `bus_en` is high and `bus_wr` is low.

Output levels and pin directions never take a plain write. Each one has a set register and a clear register: a 1 in the written word sets or clears that bit and a 0 leaves it alone, so no read-modify-write is needed. Output-state and direction-state registers read back the latches. Input-state registers return pin levels after a two-flop synchronizer. The 13-pin port also carries a pad-select latch with its own set, clear and state registers.

The mixed port places its bits at fixed positions that do not run in order. Its 6 bidirectional pins keep their output bits in bits 25..30 of the mixed output registers. Their direction bits sit in the same bits of the 13-pin port's direction registers. In the mixed input word they read at bits 10..14 and 24.

Top module: `gpio_mp`

## Requirements
- R1: After reset every output latch, direction latch and pad-select latch is 0. Every output, output-enable and pad-select pin is therefore 0, and the state registers at 0x004C, 0x0058, 0x0018, 0x000C and 0x0030 read 0.
- R2: Writing the output set register sets each output latch bit n whose write bit n is 1, and writing the clear register clears it; pin n of a plain port maps to bit n. The set/clear pairs are 0x044/0x048 for the 8-pin port A, 0x064/0x068 for the 24-pin port B and 0x020/0x024 for the 13-pin port C. Output state reads at 0x04C for A and 0x06C for B.
- R3: Write bits that are 0 leave the corresponding latch bits unchanged. A write to one port's registers leaves every other port's latches unchanged.
- R4: The direction set and clear registers make a pin an output (1) or an input (0), the output-enable pin follows the direction latch, and the direction-state register reads it back. Set, clear and state are at 0x050/0x054/0x058 for A, 0x070/0x074/0x078 for B and 0x010/0x014/0x018 for C.
- R5: The mixed output set/clear registers are at 0x004/0x008. Bits 0..23 drive output-only pins 0..23 and bits 25..30 drive the mixed bidirectional pins 0..5; bits 24 and 31 are ignored. The output-state register at 0x00C returns the latches in the same layout.
- R6: The mixed bidirectional pins take their directions from bits 25..30 of port C's direction set/clear registers, and the state register at 0x018 returns port C in bits 0..12 and the mixed directions in bits 25..30.
- R7: The mixed input word at 0x000 returns the input-only pins as follows: pins 0..9 in bits 0..9, pins 10..18 in bits 15..23 and pins 19..21 in bits 25..27. Mixed bidirectional pins 0..4 read in bits 10..14 and pin 5 in bit 24. Bits 28..31 read 0.
- R8: The input-state registers are at 0x040 for A, 0x060 for B and 0x01C for C, with pin n at bit n. A level applied to an input pin is not visible after the first rising edge and is visible after the second.
- R9: The pad-select latch of port C is set and cleared by write-one registers at 0x028/0x02C, drives `pc_mux`, and reads back at 0x030.
- R10: A read returns 0 in these cases: `bus_en` is low, the address is a write-only register, or the address is unmapped or not word aligned. A write to a read-only, unmapped or misaligned address changes no latch.
- R11: An output-state register returns the output latch and not the pin level, whatever the direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_en | input | 1 | Bus access valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| pa_in | input | PA_W | Port A pin levels |
| pa_out | output | PA_W | Port A output latch |
| pa_oe | output | PA_W | Port A output enable |
| pb_in | input | PB_W | Port B pin levels |
| pb_out | output | PB_W | Port B output latch |
| pb_oe | output | PB_W | Port B output enable |
| pc_in | input | PC_W | Port C pin levels |
| pc_out | output | PC_W | Port C output latch |
| pc_oe | output | PC_W | Port C output enable |
| pc_mux | output | PC_W | Port C pad-select latch |
| mx_in | input | 6 | Mixed bidirectional pin levels |
| mx_out | output | 6 | Mixed bidirectional output latch |
| mx_oe | output | 6 | Mixed bidirectional output enable |
| gpi_in | input | 22 | Input-only pin levels |
| gpo_out | output | 24 | Output-only pin latch |

## Verification
A set or clear write to a port can land on the same rising edge as a level change on that port's input pins. The bench provokes this by changing `pa_in` on the same edge as an output-set write to port A. It then judges that the output latch and the output-enable pins take only the written effect. It also checks that the input-state register still shows the old level after that edge and shows the new level after the next. A second overlap is covered too: one direction write updates both port C and the mixed pins, and the bench checks both groups.

// File: rtl/gpio_mp_pkg.sv
package gpio_mp_pkg;

   localparam int unsigned WORD_W       = 32;
   localparam int unsigned MX_W         = 6;
   localparam int unsigned MX_REG_LSB   = 25;
   localparam int unsigned MX_IN_LO_LSB = 10;
   localparam int unsigned MX_IN_TOP    = 24;
   localparam int unsigned GPI_W        = 22;
   localparam int unsigned GPO_W        = 24;

   localparam int unsigned OFF_M_IN   = 'h000;
   localparam int unsigned OFF_M_SET  = 'h004;
   localparam int unsigned OFF_M_CLR  = 'h008;
   localparam int unsigned OFF_M_OST  = 'h00C;
   localparam int unsigned OFF_C_DSET = 'h010;
   localparam int unsigned OFF_C_DCLR = 'h014;
   localparam int unsigned OFF_C_DST  = 'h018;
   localparam int unsigned OFF_C_IN   = 'h01C;
   localparam int unsigned OFF_C_SET  = 'h020;
   localparam int unsigned OFF_C_CLR  = 'h024;
   localparam int unsigned OFF_C_MSET = 'h028;
   localparam int unsigned OFF_C_MCLR = 'h02C;
   localparam int unsigned OFF_C_MST  = 'h030;
   localparam int unsigned OFF_A_IN   = 'h040;
   localparam int unsigned OFF_A_SET  = 'h044;
   localparam int unsigned OFF_A_CLR  = 'h048;
   localparam int unsigned OFF_A_OST  = 'h04C;
   localparam int unsigned OFF_A_DSET = 'h050;
   localparam int unsigned OFF_A_DCLR = 'h054;
   localparam int unsigned OFF_A_DST  = 'h058;
   localparam int unsigned OFF_B_IN   = 'h060;
   localparam int unsigned OFF_B_SET  = 'h064;
   localparam int unsigned OFF_B_CLR  = 'h068;
   localparam int unsigned OFF_B_OST  = 'h06C;
   localparam int unsigned OFF_B_DSET = 'h070;
   localparam int unsigned OFF_B_DCLR = 'h074;
   localparam int unsigned OFF_B_DST  = 'h078;
   localparam int unsigned OFF_TOP    = 'h07F;

   typedef struct packed {
      logic a_set, a_clr, a_dset, a_dclr;
      logic b_set, b_clr, b_dset, b_dclr;
      logic c_set, c_clr, c_dset, c_dclr;
      logic c_mset, c_mclr;
      logic m_set, m_clr;
   } wstb_t;

   typedef enum logic [3:0] {
      RS_NONE, RS_M_IN, RS_M_OST, RS_C_DST, RS_C_IN, RS_C_MST,
      RS_A_IN, RS_A_OST, RS_A_DST, RS_B_IN, RS_B_OST, RS_B_DST
   } rsel_e;

   // bit position of input-only pin k in the mixed input word
   function automatic int unsigned gpi_bit(input int unsigned k);
      if (k < 10)      return k;
      else if (k < 19) return k + 5;
      else             return k + 6;
   endfunction

   // bit position of mixed bidirectional pin p in the mixed input word
   function automatic int unsigned mx_in_bit(input int unsigned p);
      if (p < MX_W - 1) return MX_IN_LO_LSB + p;
      else              return MX_IN_TOP;
   endfunction

endpackage

// File: rtl/gpio_mp_decode.sv
module gpio_mp_decode
   import gpio_mp_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input  logic              bus_en,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   output wstb_t             wstb,
   output rsel_e             rsel
);

   always_comb begin
      wstb = '0;
      rsel = RS_NONE;
      if (bus_en && bus_wr) begin
         case (bus_addr)
            ADDR_W'(OFF_M_SET):  wstb.m_set  = 1'b1;
            ADDR_W'(OFF_M_CLR):  wstb.m_clr  = 1'b1;
            ADDR_W'(OFF_C_DSET): wstb.c_dset = 1'b1;
            ADDR_W'(OFF_C_DCLR): wstb.c_dclr = 1'b1;
            ADDR_W'(OFF_C_SET):  wstb.c_set  = 1'b1;
            ADDR_W'(OFF_C_CLR):  wstb.c_clr  = 1'b1;
            ADDR_W'(OFF_C_MSET): wstb.c_mset = 1'b1;
            ADDR_W'(OFF_C_MCLR): wstb.c_mclr = 1'b1;
            ADDR_W'(OFF_A_SET):  wstb.a_set  = 1'b1;
            ADDR_W'(OFF_A_CLR):  wstb.a_clr  = 1'b1;
            ADDR_W'(OFF_A_DSET): wstb.a_dset = 1'b1;
            ADDR_W'(OFF_A_DCLR): wstb.a_dclr = 1'b1;
            ADDR_W'(OFF_B_SET):  wstb.b_set  = 1'b1;
            ADDR_W'(OFF_B_CLR):  wstb.b_clr  = 1'b1;
            ADDR_W'(OFF_B_DSET): wstb.b_dset = 1'b1;
            ADDR_W'(OFF_B_DCLR): wstb.b_dclr = 1'b1;
            default: ;
         endcase
      end else if (bus_en) begin
         case (bus_addr)
            ADDR_W'(OFF_M_IN):  rsel = RS_M_IN;
            ADDR_W'(OFF_M_OST): rsel = RS_M_OST;
            ADDR_W'(OFF_C_DST): rsel = RS_C_DST;
            ADDR_W'(OFF_C_IN):  rsel = RS_C_IN;
            ADDR_W'(OFF_C_MST): rsel = RS_C_MST;
            ADDR_W'(OFF_A_IN):  rsel = RS_A_IN;
            ADDR_W'(OFF_A_OST): rsel = RS_A_OST;
            ADDR_W'(OFF_A_DST): rsel = RS_A_DST;
            ADDR_W'(OFF_B_IN):  rsel = RS_B_IN;
            ADDR_W'(OFF_B_OST): rsel = RS_B_OST;
            ADDR_W'(OFF_B_DST): rsel = RS_B_DST;
            default:            rsel = RS_NONE;
         endcase
      end
   end

endmodule

// File: rtl/gpio_mp_sync.sv
module gpio_mp_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_mp_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("gpio_mp_sync: W must be at least 1");
   end

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= '0;
      end else begin
         stg[0] <= d;
         for (int s = 1; s < int'(STAGES); s++) begin
            stg[s] <= stg[s-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/gpio_mp_setclr.sv
module gpio_mp_setclr #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic [W-1:0] bits,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_width
      $error("gpio_mp_setclr: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (set_we) begin
         q <= q | bits;
      end else if (clr_we) begin
         q <= q & ~bits;
      end
   end

endmodule

// File: rtl/gpio_mp_bank.sv
module gpio_mp_bank #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pin_in,
   input  logic         out_set,
   input  logic         out_clr,
   input  logic         dir_set,
   input  logic         dir_clr,
   input  logic [W-1:0] bits,
   output logic [W-1:0] in_q,
   output logic [W-1:0] out_q,
   output logic [W-1:0] dir_q
);

   gpio_mp_sync #(.W(W), .STAGES(STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (in_q)
   );

   gpio_mp_setclr #(.W(W)) i_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_we (out_set),
      .clr_we (out_clr),
      .bits   (bits),
      .q      (out_q)
   );

   gpio_mp_setclr #(.W(W)) i_dir (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_we (dir_set),
      .clr_we (dir_clr),
      .bits   (bits),
      .q      (dir_q)
   );

endmodule

// File: rtl/gpio_mp.sv
module gpio_mp
   import gpio_mp_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned PA_W        = 8,
   parameter int unsigned PB_W        = 24,
   parameter int unsigned PC_W        = 13,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [PA_W-1:0]   pa_in,
   output logic [PA_W-1:0]   pa_out,
   output logic [PA_W-1:0]   pa_oe,
   input  logic [PB_W-1:0]   pb_in,
   output logic [PB_W-1:0]   pb_out,
   output logic [PB_W-1:0]   pb_oe,
   input  logic [PC_W-1:0]   pc_in,
   output logic [PC_W-1:0]   pc_out,
   output logic [PC_W-1:0]   pc_oe,
   output logic [PC_W-1:0]   pc_mux,
   input  logic [5:0]        mx_in,
   output logic [5:0]        mx_out,
   output logic [5:0]        mx_oe,
   input  logic [21:0]       gpi_in,
   output logic [23:0]       gpo_out
);

   if ((1 << ADDR_W) <= OFF_TOP) begin : g_bad_addr
      $error("gpio_mp: ADDR_W too small for the register map");
   end
   if (PA_W < 1 || PA_W > WORD_W || PB_W < 1 || PB_W > WORD_W) begin : g_bad_ab
      $error("gpio_mp: PA_W and PB_W must lie in 1..32");
   end
   if (PC_W < 1 || PC_W > MX_REG_LSB) begin : g_bad_c
      $error("gpio_mp: PC_W must not reach the mixed direction bits");
   end
   if (GPO_W > MX_REG_LSB || MX_REG_LSB + MX_W > WORD_W) begin : g_bad_mx
      $error("gpio_mp: mixed output layout overlaps");
   end

   wstb_t wstb;
   rsel_e rsel;

   gpio_mp_decode #(.ADDR_W(ADDR_W)) i_decode (
      .bus_en   (bus_en),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .wstb     (wstb),
      .rsel     (rsel)
   );

   logic [PA_W-1:0]  pa_sync;
   logic [PB_W-1:0]  pb_sync;
   logic [PC_W-1:0]  pc_sync;
   logic [MX_W-1:0]  mx_sync;
   logic [GPI_W-1:0] gpi_sync;
   logic [GPO_W-1:0] gpo_q;

   gpio_mp_bank #(.W(PA_W), .STAGES(SYNC_STAGES)) i_bank_a (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_in  (pa_in),
      .out_set (wstb.a_set),
      .out_clr (wstb.a_clr),
      .dir_set (wstb.a_dset),
      .dir_clr (wstb.a_dclr),
      .bits    (bus_wdata[PA_W-1:0]),
      .in_q    (pa_sync),
      .out_q   (pa_out),
      .dir_q   (pa_oe)
   );

   gpio_mp_bank #(.W(PB_W), .STAGES(SYNC_STAGES)) i_bank_b (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_in  (pb_in),
      .out_set (wstb.b_set),
      .out_clr (wstb.b_clr),
      .dir_set (wstb.b_dset),
      .dir_clr (wstb.b_dclr),
      .bits    (bus_wdata[PB_W-1:0]),
      .in_q    (pb_sync),
      .out_q   (pb_out),
      .dir_q   (pb_oe)
   );

   gpio_mp_bank #(.W(PC_W), .STAGES(SYNC_STAGES)) i_bank_c (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_in  (pc_in),
      .out_set (wstb.c_set),
      .out_clr (wstb.c_clr),
      .dir_set (wstb.c_dset),
      .dir_clr (wstb.c_dclr),
      .bits    (bus_wdata[PC_W-1:0]),
      .in_q    (pc_sync),
      .out_q   (pc_out),
      .dir_q   (pc_oe)
   );

   // mixed bidirectional pins: outputs on the mixed registers, directions
   // on port C's direction registers, both in the upper bit field
   gpio_mp_bank #(.W(MX_W), .STAGES(SYNC_STAGES)) i_bank_mx (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_in  (mx_in),
      .out_set (wstb.m_set),
      .out_clr (wstb.m_clr),
      .dir_set (wstb.c_dset),
      .dir_clr (wstb.c_dclr),
      .bits    (bus_wdata[MX_REG_LSB +: MX_W]),
      .in_q    (mx_sync),
      .out_q   (mx_out),
      .dir_q   (mx_oe)
   );

   gpio_mp_setclr #(.W(GPO_W)) i_gpo (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_we (wstb.m_set),
      .clr_we (wstb.m_clr),
      .bits   (bus_wdata[GPO_W-1:0]),
      .q      (gpo_q)
   );

   gpio_mp_setclr #(.W(PC_W)) i_mux (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_we (wstb.c_mset),
      .clr_we (wstb.c_mclr),
      .bits   (bus_wdata[PC_W-1:0]),
      .q      (pc_mux)
   );

   gpio_mp_sync #(.W(GPI_W), .STAGES(SYNC_STAGES)) i_gpi_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (gpi_in),
      .q     (gpi_sync)
   );

   assign gpo_out = gpo_q;

   logic unused_wdata;
   assign unused_wdata = ^bus_wdata;

   // scattered mixed input word
   logic [WORD_W-1:0] mx_word;
   always_comb begin
      mx_word = '0;
      for (int unsigned k = 0; k < GPI_W; k++) begin
         mx_word[gpi_bit(k)] = gpi_sync[k];
      end
      for (int unsigned p = 0; p < MX_W; p++) begin
         mx_word[mx_in_bit(p)] = mx_sync[p];
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (rsel)
         RS_M_IN:  bus_rdata = mx_word;
         RS_M_OST: begin
            bus_rdata[GPO_W-1:0]           = gpo_q;
            bus_rdata[MX_REG_LSB +: MX_W]  = mx_out;
         end
         RS_C_DST: begin
            bus_rdata[PC_W-1:0]            = pc_oe;
            bus_rdata[MX_REG_LSB +: MX_W]  = mx_oe;
         end
         RS_C_IN:  bus_rdata[PC_W-1:0] = pc_sync;
         RS_C_MST: bus_rdata[PC_W-1:0] = pc_mux;
         RS_A_IN:  bus_rdata[PA_W-1:0] = pa_sync;
         RS_A_OST: bus_rdata[PA_W-1:0] = pa_out;
         RS_A_DST: bus_rdata[PA_W-1:0] = pa_oe;
         RS_B_IN:  bus_rdata[PB_W-1:0] = pb_sync;
         RS_B_OST: bus_rdata[PB_W-1:0] = pb_out;
         RS_B_DST: bus_rdata[PB_W-1:0] = pb_oe;
         default:  bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/gpio_mp_chk.sv
module gpio_mp_chk
   import gpio_mp_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned PA_W        = 8,
   parameter int unsigned PB_W        = 24,
   parameter int unsigned PC_W        = 13,
   parameter int unsigned SYNC_STAGES = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_en,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       bus_rdata,
   input logic [PA_W-1:0]   pa_in,
   input logic [PA_W-1:0]   pa_out,
   input logic [PA_W-1:0]   pa_oe,
   input logic [PB_W-1:0]   pb_out,
   input logic [PC_W-1:0]   pc_mux,
   input logic [5:0]        mx_out,
   input logic [5:0]        mx_oe,
   input logic [23:0]       gpo_out
);

   logic wr, rd;
   assign wr = bus_en && bus_wr;
   assign rd = bus_en && !bus_wr;

   logic [2:0] cyc;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cyc <= '0;
      else if (cyc != 3'd7) cyc <= cyc + 3'd1;
   end

   AST_A_SET_OR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && bus_addr == ADDR_W'(OFF_A_SET)) |=>
      pa_out == ($past(pa_out) | $past(bus_wdata[PA_W-1:0]))); // R2

   AST_B_CLR_AND: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && bus_addr == ADDR_W'(OFF_B_CLR)) |=>
      pb_out == ($past(pb_out) & ~$past(bus_wdata[PB_W-1:0]))); // R2

   AST_A_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && (bus_addr == ADDR_W'(OFF_A_SET) || bus_addr == ADDR_W'(OFF_A_CLR)))
      |=> $stable(pa_out)); // R3

   AST_A_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && (bus_addr == ADDR_W'(OFF_A_DSET) || bus_addr == ADDR_W'(OFF_A_DCLR)))
      |=> $stable(pa_oe)); // R4

   AST_MX_OUT_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && bus_addr == ADDR_W'(OFF_M_SET)) |=>
      (mx_out == ($past(mx_out) | $past(bus_wdata[30:25])) &&
       gpo_out == ($past(gpo_out) | $past(bus_wdata[23:0])))); // R5

   AST_MX_DIR_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && bus_addr == ADDR_W'(OFF_C_DSET)) |=>
      mx_oe == ($past(mx_oe) | $past(bus_wdata[30:25]))); // R6

   AST_MUX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && (bus_addr == ADDR_W'(OFF_C_MSET) || bus_addr == ADDR_W'(OFF_C_MCLR)))
      |=> $stable(pc_mux)); // R9

   AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_en || (rd && bus_addr == ADDR_W'(OFF_A_SET))) |-> bus_rdata == '0); // R10

   AST_OST_IS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && bus_addr == ADDR_W'(OFF_A_OST)) |-> bus_rdata[PA_W-1:0] == pa_out); // R11

   if (SYNC_STAGES == 2) begin : g_sync_chk
      AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
         (cyc >= 3'd2 && rd && bus_addr == ADDR_W'(OFF_A_IN)) |->
         bus_rdata[PA_W-1:0] == $past(pa_in, 2)); // R8
   end

endmodule

bind gpio_mp gpio_mp_chk #(
   .ADDR_W      (ADDR_W),
   .PA_W        (PA_W),
   .PB_W        (PB_W),
   .PC_W        (PC_W),
   .SYNC_STAGES (SYNC_STAGES)
) i_chk (.*);

// File: tb/test_gpio_mp.sv
module test_gpio_mp;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_en = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  pa_in = '0;
   logic [7:0]  pa_out, pa_oe;
   logic [23:0] pb_in = '0;
   logic [23:0] pb_out, pb_oe;
   logic [12:0] pc_in = '0;
   logic [12:0] pc_out, pc_oe, pc_mux;
   logic [5:0]  mx_in = '0;
   logic [5:0]  mx_out, mx_oe;
   logic [21:0] gpi_in = '0;
   logic [23:0] gpo_out;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_mp i_gpio_mp (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
      .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
      .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe), .pc_mux(pc_mux),
      .mx_in(mx_in), .mx_out(mx_out), .mx_oe(mx_oe),
      .gpi_in(gpi_in), .gpo_out(gpo_out)
   );

   task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", what, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      #1;
      bus_en = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic bus_read_now(input logic [7:0] a, output logic [31:0] d);
      bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1;
      d = bus_rdata;
      bus_en = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_read_now(a, d);
   endtask

   // expected mixed input word, from the bit layout of R7
   function automatic logic [31:0] mx_word(input logic [5:0] m, input logic [21:0] g);
      logic [31:0] w = '0;
      for (int k = 0; k < 10; k++)  w[k]      = g[k];
      for (int k = 10; k < 19; k++) w[k + 5]  = g[k];
      for (int k = 19; k < 22; k++) w[k + 6]  = g[k];
      for (int p = 0; p < 5; p++)   w[10 + p] = m[p];
      w[24] = m[5];
      return w;
   endfunction

   task automatic t_reset();
      logic [31:0] r;
      check("R1 pa_out/oe", {pa_out, pa_oe}, '0);
      check("R1 pb_out/oe", {pb_out, pb_oe}, '0);
      check("R1 pc_out/oe/mux", {pc_out, pc_oe, pc_mux}, '0);
      check("R1 mixed/gpo", {mx_out, mx_oe, gpo_out}, '0);
      bus_read(8'h4C, r); check("R1 A out state", r, '0);
      bus_read(8'h58, r); check("R1 A dir state", r, '0);
      bus_read(8'h18, r); check("R1 C dir state", r, '0);
      bus_read(8'h0C, r); check("R1 mixed out state", r, '0);
      bus_read(8'h30, r); check("R1 mux state", r, '0);
   endtask

   task automatic t_plain_setclr();
      logic [31:0] r;
      bus_write(8'h44, 32'hFFFF_FFA5); check("R2 A set", pa_out, 8'hA5);
      bus_read(8'h4C, r);             check("R2 A out state", r, 32'hA5);
      bus_write(8'h48, 32'h05);       check("R2 A clr", pa_out, 8'hA0);
      bus_write(8'h44, 32'h0);        check("R3 A zero set", pa_out, 8'hA0);
      bus_write(8'h48, 32'h0);        check("R3 A zero clr", pa_out, 8'hA0);
      bus_write(8'h64, 32'h00F00F);   check("R2 B set", pb_out, 24'h00F00F);
      check("R3 A untouched by B", pa_out, 8'hA0);
      bus_write(8'h68, 32'h00000F);   check("R2 B clr", pb_out, 24'h00F000);
      bus_read(8'h6C, r);             check("R2 B out state", r, 32'h00F000);
      bus_write(8'h20, 32'h1FFF);     check("R2 C set", pc_out, 13'h1FFF);
      bus_write(8'h24, 32'h1000);     check("R2 C clr", pc_out, 13'h0FFF);
      check("R3 B untouched by C", pb_out, 24'h00F000);
   endtask

   task automatic t_dir();
      logic [31:0] r;
      bus_write(8'h50, 32'h0F);       check("R4 A dir set", pa_oe, 8'h0F);
      bus_read(8'h58, r);             check("R4 A dir state", r, 32'h0F);
      bus_write(8'h54, 32'h03);       check("R4 A dir clr", pa_oe, 8'h0C);
      bus_write(8'h70, 32'hFFFFFF);   check("R4 B dir set", pb_oe, 24'hFFFFFF);
      bus_write(8'h74, 32'h800001);   check("R4 B dir clr", pb_oe, 24'h7FFFFE);
      bus_read(8'h78, r);             check("R4 B dir state", r, 32'h7FFFFE);
      check("R3 A out untouched by dir", pa_out, 8'hA0);
   endtask

   task automatic t_shared_dir();
      logic [31:0] r;
      bus_write(8'h10, 32'h7E00_1FFF);
      check("R4 C dir set", pc_oe, 13'h1FFF);
      check("R6 mixed dir set", mx_oe, 6'h3F);
      bus_read(8'h18, r); check("R6 shared dir state", r, 32'h7E00_1FFF);
      bus_write(8'h14, 32'h0200_0001);
      check("R4 C dir clr", pc_oe, 13'h1FFE);
      check("R6 mixed dir clr", mx_oe, 6'h3E);
      bus_read(8'h18, r); check("R6 shared dir state 2", r, 32'h7C00_1FFE);
      check("R3 B dir untouched", pb_oe, 24'h7FFFFE);
   endtask

   task automatic t_mixed_out();
      logic [31:0] r;
      bus_write(8'h04, 32'hFFFF_FFFF);
      check("R5 gpo set", gpo_out, 24'hFFFFFF);
      check("R5 mixed out set", mx_out, 6'h3F);
      bus_read(8'h0C, r); check("R5 mixed out state", r, 32'h7EFF_FFFF);
      bus_write(8'h08, 32'h8200_0001);
      check("R5 gpo clr", gpo_out, 24'hFFFFFE);
      check("R5 mixed out clr", mx_out, 6'h3E);
      bus_read(8'h0C, r); check("R5 mixed out state 2", r, 32'h7CFF_FFFE);
      check("R3 C out untouched", pc_out, 13'h0FFF);
   endtask

   task automatic t_inputs();
      logic [31:0] r;
      @(negedge clk);
      pa_in = 8'h5A; pb_in = 24'hC3A5F0; pc_in = 13'h1555;
      mx_in = 6'b100001; gpi_in = 22'h2AAAAA;
      repeat (3) @(posedge clk);
      bus_read(8'h40, r); check("R8 A in", r, 32'h5A);
      bus_read(8'h60, r); check("R8 B in", r, 32'hC3A5F0);
      bus_read(8'h1C, r); check("R8 C in", r, 32'h1555);
      bus_read(8'h00, r); check("R7 mixed in a", r, mx_word(6'b100001, 22'h2AAAAA));
      @(negedge clk);
      mx_in = 6'b011110; gpi_in = 22'h155555;
      repeat (3) @(posedge clk);
      bus_read(8'h00, r); check("R7 mixed in b", r, mx_word(6'b011110, 22'h155555));
   endtask

   task automatic t_sync();
      logic [31:0] r;
      @(negedge clk);
      pa_in = 8'h3C;
      @(posedge clk); #2;
      bus_read_now(8'h40, r); check("R8 not after first edge", r, 32'h5A);
      @(posedge clk); #2;
      bus_read_now(8'h40, r); check("R8 after second edge", r, 32'h3C);
   endtask

   task automatic t_latch_not_pad();
      logic [31:0] r;
      @(negedge clk);
      pa_in = 8'hFF;
      repeat (3) @(posedge clk);
      bus_read(8'h4C, r); check("R11 out state is latch", r, 32'hA0);
   endtask

   task automatic t_mux();
      logic [31:0] r;
      bus_write(8'h28, 32'h1234); check("R9 mux set", pc_mux, 13'h1234);
      bus_write(8'h2C, 32'h0030); check("R9 mux clr", pc_mux, 13'h1204);
      bus_read(8'h30, r);         check("R9 mux state", r, 32'h1204);
      check("R3 C out untouched by mux", pc_out, 13'h0FFF);
   endtask

   task automatic t_unmapped();
      logic [31:0] r;
      bus_write(8'h34, 32'hFFFF_FFFF);
      bus_write(8'h7C, 32'hFFFF_FFFF);
      bus_write(8'h45, 32'hFFFF_FFFF);
      bus_write(8'h4C, 32'hFFFF_FFFF);
      bus_write(8'h00, 32'hFFFF_FFFF);
      bus_write(8'h30, 32'hFFFF_FFFF);
      bus_write(8'h18, 32'h0);
      check("R10 A after bad writes", {pa_out, pa_oe}, {8'hA0, 8'h0C});
      check("R10 B after bad writes", pb_out, 24'h00F000);
      check("R10 C after bad writes", {pc_out, pc_oe, pc_mux}, {13'h0FFF, 13'h1FFE, 13'h1204});
      check("R10 mixed after bad writes", {mx_out, mx_oe, gpo_out}, {6'h3E, 6'h3E, 24'hFFFFFE});
      bus_read(8'h34, r); check("R10 unmapped read", r, '0);
      bus_read(8'h44, r); check("R10 write-only read", r, '0);
      bus_read(8'h4D, r); check("R10 misaligned read", r, '0);
      @(negedge clk);
      bus_en = 1'b0; bus_wr = 1'b0; bus_addr = 8'h4C;
      #1; check("R10 idle read", bus_rdata, '0);
   endtask

   task automatic t_same_cycle();
      logic [31:0] r;
      @(negedge clk);
      pa_in = 8'h81;
      bus_en = 1'b1; bus_wr = 1'b1; bus_addr = 8'h44; bus_wdata = 32'h01;
      @(posedge clk); #1;
      bus_en = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
      check("R2 same-cycle set", pa_out, 8'hA1);
      check("R4 same-cycle dir kept", pa_oe, 8'h0C);
      #1; bus_read_now(8'h40, r); check("R8 same-cycle old input", r, 32'hFF);
      @(posedge clk); #2;
      bus_read_now(8'h40, r); check("R8 same-cycle new input", r, 32'h81);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_plain_setclr();
      t_dir();
      t_shared_dir();
      t_mixed_out();
      t_inputs();
      t_sync();
      t_latch_not_pad();
      t_mux();
      t_unmapped();
      t_same_cycle();
      repeat (2) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule